// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Message Unit

Two processors, called side A and side B, swap words and signals through this unit. Each side owns a simple 32-bit register port with a write strobe, a read strobe and a byte address. A word written into one of a side's four outgoing data slots lands in the matching incoming slot of the other side. Per-channel flags tell each side when an outgoing slot has been consumed and when an incoming slot holds a fresh word.

A side can also ring the other side without data. It sets a request bit, which raises a sticky pending flag on the other side that software clears by writing one. Each side has one interrupt line that combines every flag with its enable. Either side can ask for a unit-wide reset. The reset runs for a fixed number of cycles, shows a busy bit on both sides, and then returns both sides to their idle state.

Top module: `ipc_msg_unit`

## Requirements
- R1: After reset, each side's status word reads 0x00F0_0000 (all four outgoing-empty flags set, everything else clear), each control word reads 0, and both interrupt lines are low.
- R2: Channel n is placed at bit base+(3-n). In the status word (offset 0x20) the bases are 28 for pending, 24 for incoming-full and 20 for outgoing-empty, and bit 7 is reset-busy. In the control word (offset 0x24) the bases are 28 for pending enable, 24 for incoming enable, 20 for outgoing enable and 16 for request, and bit 5 is reset.
- R3: A write to outgoing slot n (offset 4n) clears the writer's outgoing-empty flag n. On the same clock edge it sets the other side's incoming-full flag n and loads the word into the other side's incoming slot n.
- R4: Reading incoming slot n (offset 0x10+4n) returns the stored word, clears the reader's incoming-full flag n, and sets the other side's outgoing-empty flag n on that edge.
- R5: Writing 1 to request bit n sets the other side's pending flag n one edge after the request bit becomes visible. The request bit then clears itself one edge later.
- R6: A pending flag stays set until its own side writes 1 to that status bit. Writing 0 to it has no effect.
- R7: A side's interrupt line is high exactly while some flag (pending, incoming-full or outgoing-empty) has its matching enable set. It responds in the same cycle as the flag.
- R8: Writing control bit 5 starts a unit reset. For RST_CYCLES cycles, status bit 7 and control bit 5 read 1 on both sides. After that, both sides hold their R1 values.
- R9: Outgoing slots read back as 0. Writes to incoming slots, to non-pending status bits and to byte addresses that are not multiples of 4 change nothing.
- R10: If the other side writes slot n on the same edge as the local side reads incoming slot n, the new word wins. Incoming-full stays set with the new word, and the writer's outgoing-empty flag n stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe (triggers read side effects) |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational from a_addr |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
Read data is combinational, so the value of a read is sampled in the cycle the address is driven. Its side effect lands on the following edge. Data writes, incoming reads and pending clears show up in the status word one edge after the strobe. A request reaches the other side's pending flag two edges after the write and retires on the third edge. The bench drives on falling edges and samples one nanosecond later, so every check sees exactly the state after the intended number of rising edges. The reset window is polled once per cycle for all RST_CYCLES cycles and then once more, where the idle values are due.

// File: rtl/ipc_msg_pkg.sv
package ipc_msg_pkg;
    localparam int NCH    = 4;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;

    // mirrored field bases
    localparam int GP_BASE = 28;
    localparam int RF_BASE = 24;
    localparam int TE_BASE = 20;
    localparam int RQ_BASE = 16;
    localparam int BUSY_BIT = 7;
    localparam int RST_BIT  = 5;

    // word indices (byte address / 4)
    localparam logic [3:0] WI_TX0  = 4'd0;
    localparam logic [3:0] WI_RX0  = 4'd4;
    localparam logic [3:0] WI_STAT = 4'd8;
    localparam logic [3:0] WI_CTRL = 4'd9;

    typedef logic [NCH-1:0]   chmask_t;
    typedef logic [REG_W-1:0] word_t;

    typedef struct packed {
        chmask_t tx_empty;
        chmask_t rx_full;
        chmask_t pend;
        chmask_t gie;
        chmask_t rie;
        chmask_t tie;
        chmask_t req;
    } flags_t;

    typedef struct packed {
        flags_t           f;
        word_t [NCH-1:0]  rx;
    } side_st_t;

    function automatic int bitpos(input int base, input int n);
        return base + NCH - 1 - n;
    endfunction

    function automatic word_t spread(input chmask_t m, input int base);
        word_t w = '0;
        for (int n = 0; n < NCH; n++) w[bitpos(base, n)] = m[n];
        return w;
    endfunction

    function automatic chmask_t gather(input word_t w, input int base);
        chmask_t m = '0;
        for (int n = 0; n < NCH; n++) m[n] = w[bitpos(base, n)];
        return m;
    endfunction

    function automatic side_st_t idle_state();
        side_st_t s = '0;
        s.f.tx_empty = '1;
        return s;
    endfunction
endpackage

// File: rtl/ipc_reset_seq.sv
module ipc_reset_seq #(
    parameter int RST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] start,
    output logic       busy,
    output logic       clr
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        clr   = seq_q.busy && (seq_q.cnt == '0);
        if (clr) begin
            seq_d.busy = 1'b0;
        end else if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end else if (|start) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = CW'(RST_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;
endmodule

// File: rtl/ipc_side_regs.sv
module ipc_side_regs
    import ipc_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              busy,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output word_t             rdata,
    output logic              irq,
    output logic              rst_req,
    output chmask_t           tx_wr,
    output chmask_t           rx_rd,
    output chmask_t           req,
    output chmask_t           pend,
    output chmask_t           tx_empty,
    output chmask_t           rx_full,
    input  chmask_t           peer_tx_wr,
    input  chmask_t           peer_rx_rd,
    input  chmask_t           peer_req,
    input  chmask_t           peer_pend,
    input  word_t             peer_word
);
    side_st_t   st_d, st_q;
    logic [3:0] widx;
    logic       aligned;
    logic       stat_wr;
    logic       ctrl_wr;
    chmask_t    clr_mask;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        st_d     = st_q;
        tx_wr    = '0;
        rx_rd    = '0;
        stat_wr  = wr_en && aligned && (widx == WI_STAT);
        ctrl_wr  = wr_en && aligned && (widx == WI_CTRL);
        rst_req  = ctrl_wr && wdata[RST_BIT];
        clr_mask = stat_wr ? gather(wdata, GP_BASE) : '0;
        for (int n = 0; n < NCH; n++) begin
            tx_wr[n] = wr_en && aligned && (widx == WI_TX0 + 4'(n));
            rx_rd[n] = rd_en && aligned && (widx == WI_RX0 + 4'(n));
            // own write beats the peer's consumption
            if (tx_wr[n])           st_d.f.tx_empty[n] = 1'b0;
            else if (peer_rx_rd[n]) st_d.f.tx_empty[n] = 1'b1;
            // fresh word beats the local read
            if (peer_tx_wr[n]) begin
                st_d.f.rx_full[n] = 1'b1;
                st_d.rx[n]        = peer_word;
            end else if (rx_rd[n]) begin
                st_d.f.rx_full[n] = 1'b0;
            end
            // set beats write-one-to-clear
            if (peer_req[n])       st_d.f.pend[n] = 1'b1;
            else if (clr_mask[n])  st_d.f.pend[n] = 1'b0;
        end
        st_d.f.req = st_q.f.req & ~peer_pend;
        if (ctrl_wr) begin
            st_d.f.gie = gather(wdata, GP_BASE);
            st_d.f.rie = gather(wdata, RF_BASE);
            st_d.f.tie = gather(wdata, TE_BASE);
            st_d.f.req = st_d.f.req | gather(wdata, RQ_BASE);
        end
        if (soft_clr) st_d = idle_state();
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= idle_state();
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (widx[3:2] == 2'b01) begin
                rdata = st_q.rx[widx[1:0]];
            end else if (widx == WI_STAT) begin
                rdata = spread(st_q.f.pend, GP_BASE) | spread(st_q.f.rx_full, RF_BASE)
                      | spread(st_q.f.tx_empty, TE_BASE);
                rdata[BUSY_BIT] = busy;
            end else if (widx == WI_CTRL) begin
                rdata = spread(st_q.f.gie, GP_BASE) | spread(st_q.f.rie, RF_BASE)
                      | spread(st_q.f.tie, TE_BASE) | spread(st_q.f.req, RQ_BASE);
                rdata[RST_BIT] = busy;
            end
        end
    end

    assign irq = |(st_q.f.pend & st_q.f.gie) | |(st_q.f.rx_full & st_q.f.rie)
               | |(st_q.f.tx_empty & st_q.f.tie);

    assign req      = st_q.f.req;
    assign pend     = st_q.f.pend;
    assign tx_empty = st_q.f.tx_empty;
    assign rx_full  = st_q.f.rx_full;
endmodule

// File: rtl/ipc_msg_unit.sv
module ipc_msg_unit
    import ipc_msg_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        a_wr_en,
    input  logic        a_rd_en,
    input  logic [5:0]  a_addr,
    input  logic [31:0] a_wdata,
    output logic [31:0] a_rdata,
    output logic        a_irq,
    input  logic        b_wr_en,
    input  logic        b_rd_en,
    input  logic [5:0]  b_addr,
    input  logic [31:0] b_wdata,
    output logic [31:0] b_rdata,
    output logic        b_irq
);
    logic [1:0]              wr_v, rd_v, irq_v, rst_req_v;
    logic [1:0][ADDR_W-1:0]  addr_v;
    word_t [1:0]             wdata_v, rdata_v;
    logic [1:0][NCH-1:0]     tx_wr_v, rx_rd_v, req_v, pend_v, tx_empty_v, rx_full_v;
    logic                    busy, clr;

    assign wr_v    = {b_wr_en, a_wr_en};
    assign rd_v    = {b_rd_en, a_rd_en};
    assign addr_v  = {b_addr, a_addr};
    assign wdata_v = {b_wdata, a_wdata};

    ipc_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .start(rst_req_v), .busy(busy), .clr(clr)
    );

    for (genvar s = 0; s < 2; s++) begin : g_side
        ipc_side_regs u_side (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_clr   (clr),
            .busy       (busy),
            .wr_en      (wr_v[s]),
            .rd_en      (rd_v[s]),
            .addr       (addr_v[s]),
            .wdata      (wdata_v[s]),
            .rdata      (rdata_v[s]),
            .irq        (irq_v[s]),
            .rst_req    (rst_req_v[s]),
            .tx_wr      (tx_wr_v[s]),
            .rx_rd      (rx_rd_v[s]),
            .req        (req_v[s]),
            .pend       (pend_v[s]),
            .tx_empty   (tx_empty_v[s]),
            .rx_full    (rx_full_v[s]),
            .peer_tx_wr (tx_wr_v[1-s]),
            .peer_rx_rd (rx_rd_v[1-s]),
            .peer_req   (req_v[1-s]),
            .peer_pend  (pend_v[1-s]),
            .peer_word  (wdata_v[1-s])
        );
    end

    assign a_rdata = rdata_v[0];
    assign b_rdata = rdata_v[1];
    assign a_irq   = irq_v[0];
    assign b_irq   = irq_v[1];
endmodule

// File: rtl/ipc_msg_unit_chk.sv
module ipc_msg_unit_chk
    import ipc_msg_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                a_wr_en,
    input logic [5:0]          a_addr,
    input logic                b_wr_en,
    input logic                b_rd_en,
    input logic [5:0]          b_addr,
    input logic [1:0][NCH-1:0] tx_empty_v,
    input logic [1:0][NCH-1:0] rx_full_v,
    input logic [1:0][NCH-1:0] req_v,
    input logic [1:0][NCH-1:0] pend_v,
    input logic                busy,
    input logic                clr
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        // R3
        p_tx_fills_peer_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (a_wr_en && a_addr == 6'(ch*4) && !clr) |=> (rx_full_v[1][ch] && !tx_empty_v[0][ch]));
        // R4
        p_rd_frees_peer_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (b_rd_en && b_addr == 6'(16 + ch*4) && !(a_wr_en && a_addr == 6'(ch*4)) && !clr)
            |=> (tx_empty_v[0][ch] && !rx_full_v[1][ch]));
        // R5
        p_req_raises_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_v[0][ch] && !clr) |=> pend_v[1][ch]);
        // R6
        p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_v[1][ch] && !clr && !(b_wr_en && b_addr == 6'h20)) |=> pend_v[1][ch]);
    end

    // R8
    p_reset_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tx_empty_v == '1 && rx_full_v == '0 && pend_v == '0 && req_v == '0));
endmodule

bind ipc_msg_unit ipc_msg_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .a_wr_en(a_wr_en), .a_addr(a_addr),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr),
    .tx_empty_v(tx_empty_v), .rx_full_v(rx_full_v), .req_v(req_v),
    .pend_v(pend_v), .busy(busy), .clr(clr)
);

// File: tb/ipc_msg_unit_tb_top.sv
`timescale 1ns/1ps
module ipc_msg_unit_tb_top;
    localparam int RSTC = 4;
    localparam logic [31:0] IDLE = 32'h00F0_0000;

    typedef struct packed {
        logic        src;
        logic [1:0]  ch;
        logic [31:0] word;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 2'd0, 32'hA5A5_0001},
        '{1'b0, 2'd3, 32'h0000_FFFF},
        '{1'b1, 2'd1, 32'h1234_5678},
        '{1'b1, 2'd2, 32'hFFFF_0000},
        '{1'b0, 2'd2, 32'h8000_0001},
        '{1'b1, 2'd3, 32'hCAFE_F00D}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic a_irq, b_irq;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ipc_msg_unit #(.RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    function automatic logic [31:0] fb(input int base, input int n);
        return 32'(1) << (base + 3 - n);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // starts and ends on a falling edge
    task automatic acc(input logic side, input logic wr, input logic rd, input logic [5:0] ad,
                       input logic [31:0] d, output logic [31:0] q);
        if (!side) begin a_wr_en = wr; a_rd_en = rd; a_addr = ad; a_wdata = d; end
        else       begin b_wr_en = wr; b_rd_en = rd; b_addr = ad; b_wdata = d; end
        #1;
        q = side ? b_rdata : a_rdata;
        @(negedge clk);
        a_wr_en = 0; a_rd_en = 0; b_wr_en = 0; b_rd_en = 0;
    endtask

    task automatic wr(input logic side, input logic [5:0] ad, input logic [31:0] d);
        logic [31:0] q;
        acc(side, 1'b1, 1'b0, ad, d, q);
    endtask

    task automatic rd(input logic side, input logic [5:0] ad, output logic [31:0] q);
        acc(side, 1'b0, 1'b1, ad, 32'h0, q);
    endtask

    task automatic peek2(input logic [5:0] aa, input logic [5:0] ba,
                         output logic [31:0] qa, output logic [31:0] qb);
        a_addr = aa; b_addr = ba;
        #1;
        qa = a_rdata; qb = b_rdata;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] qa, qb, q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek2(6'h20, 6'h20, qa, qb);
        chk("R1 status A", qa, IDLE);
        chk("R1 status B", qb, IDLE);
        peek2(6'h24, 6'h24, qa, qb);
        chk("R1 ctrl A", qa, 32'h0);
        chk("R1 ctrl B", qb, 32'h0);
        chk("R1 irqs", {30'h0, b_irq, a_irq}, 32'h0);

        // R3 / R4 / R2 vector walk
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            logic [31:0] qs, qd;
            wr(v.src, 6'(v.ch * 4), v.word);
            peek2(6'h20, 6'h20, qa, qb);
            qs = v.src ? qb : qa;
            qd = v.src ? qa : qb;
            chk("R3 writer status", qs, IDLE & ~fb(20, v.ch));
            chk("R3 receiver status", qd, IDLE | fb(24, v.ch));
            rd(~v.src, 6'(16 + v.ch * 4), q);
            chk("R4 received word", q, v.word);
            peek2(6'h20, 6'h20, qa, qb);
            chk("R4 status A", qa, IDLE);
            chk("R4 status B", qb, IDLE);
        end

        // R9 ignored accesses
        wr(1'b0, 6'h00, 32'hDEAD_BEEF);
        rd(1'b0, 6'h00, q);
        chk("R9 tx reads zero", q, 32'h0);
        wr(1'b1, 6'h10, 32'h0000_1234);
        wr(1'b1, 6'h11, 32'h0000_5678);
        wr(1'b1, 6'h20, 32'h0FFF_FFFF);
        wr(1'b0, 6'h20, 32'h0FFF_FFFF);
        peek2(6'h20, 6'h20, qa, qb);
        chk("R9 status A unchanged", qa, IDLE & ~fb(20, 0));
        chk("R9 status B unchanged", qb, IDLE | fb(24, 0));
        rd(1'b1, 6'h10, q);
        chk("R9 rx slot unchanged", q, 32'hDEAD_BEEF);

        // R10 simultaneous write and read of channel 1
        wr(1'b0, 6'h04, 32'h1111_1111);
        a_wr_en = 1; a_addr = 6'h04; a_wdata = 32'h2222_2222;
        b_rd_en = 1; b_addr = 6'h14;
        #1 q = b_rdata;
        @(negedge clk);
        a_wr_en = 0; b_rd_en = 0;
        chk("R10 old word read", q, 32'h1111_1111);
        peek2(6'h20, 6'h20, qa, qb);
        chk("R10 writer stays busy", qa, IDLE & ~fb(20, 1));
        chk("R10 receiver stays full", qb, IDLE | fb(24, 1));
        rd(1'b1, 6'h14, q);
        chk("R10 new word kept", q, 32'h2222_2222);

        // R5 request A->B channel 3, timing
        wr(1'b0, 6'h24, fb(16, 3));
        peek2(6'h24, 6'h20, qa, qb);
        chk("R5 request visible", qa, fb(16, 3));
        chk("R5 pending not yet", qb, IDLE);
        peek2(6'h24, 6'h20, qa, qb);
        chk("R5 request held", qa, fb(16, 3));
        chk("R5 pending set", qb, IDLE | fb(28, 3));
        peek2(6'h24, 6'h20, qa, qb);
        chk("R5 request retired", qa, 32'h0);
        // R6 write-one-to-clear
        wr(1'b1, 6'h20, 32'h0);
        peek2(6'h20, 6'h20, qa, qb);
        chk("R6 zero write keeps pending", qb, IDLE | fb(28, 3));
        wr(1'b1, 6'h20, fb(28, 3));
        peek2(6'h20, 6'h20, qa, qb);
        chk("R6 pending cleared", qb, IDLE);
        // R5 B->A channel 0
        wr(1'b1, 6'h24, fb(16, 0));
        peek2(6'h20, 6'h24, qa, qb);
        peek2(6'h20, 6'h24, qa, qb);
        chk("R5 pending on A", qa, IDLE | fb(28, 0));
        wr(1'b0, 6'h20, fb(28, 0));

        // R7 interrupts
        wr(1'b0, 6'h24, fb(20, 0));
        #1 chk("R7 empty irq", {31'h0, a_irq}, 32'h1);
        @(negedge clk);
        wr(1'b0, 6'h00, 32'h0BAD_0001);
        #1 chk("R7 irq drops on fill", {31'h0, a_irq}, 32'h0);
        @(negedge clk);
        wr(1'b1, 6'h24, fb(24, 0));
        #1 chk("R7 full irq", {31'h0, b_irq}, 32'h1);
        @(negedge clk);
        rd(1'b1, 6'h10, q);
        #1 chk("R7 irqs after read", {30'h0, b_irq, a_irq}, 32'h1);
        @(negedge clk);
        wr(1'b0, 6'h24, fb(28, 2));
        #1 chk("R7 disabled flags quiet", {31'h0, a_irq}, 32'h0);
        @(negedge clk);
        wr(1'b1, 6'h24, fb(16, 2));
        peek2(6'h20, 6'h20, qa, qb);
        #1 chk("R7 pending irq", {31'h0, a_irq}, 32'h1);
        @(negedge clk);
        wr(1'b0, 6'h20, fb(28, 2));
        #1 chk("R7 irq after clear", {31'h0, a_irq}, 32'h0);
        @(negedge clk);

        // R8 unit reset with dirty state
        wr(1'b0, 6'h08, 32'h5555_AAAA);
        wr(1'b1, 6'h24, fb(24, 1) | fb(20, 3));
        wr(1'b0, 6'h24, 32'h0000_0020);
        for (int k = 0; k < RSTC; k++) begin
            peek2(6'h24, 6'h20, qa, qb);
            chk("R8 reset bit held", qa & 32'h20, 32'h20);
            chk("R8 busy seen by peer", qb & 32'h80, 32'h80);
        end
        peek2(6'h20, 6'h20, qa, qb);
        chk("R8 status A idle", qa, IDLE);
        chk("R8 status B idle", qb, IDLE);
        peek2(6'h24, 6'h24, qa, qb);
        chk("R8 ctrl cleared", qa | qb, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule